// File: doc/BRIEF.md
# Fibonacci Transition-Coded Bus Decoder

This block sits at the receiving end of a long on-chip bus whose sender maps each data word onto a codeword built from Fibonacci-weighted bits. The sender then signals the word by transitions: it XORs the codeword into the wires, so a wire toggles only where the codeword bit is 1. In normal-form coding, no two adjacent codeword bits are 1. As a result, two neighbouring wires never switch in opposite directions in the same cycle. That removes the worst-case coupling delay on the bus.

The decoder keeps the last accepted bus value. On each valid cycle it XORs that value with the incoming wires to recover the codeword. It then adds the Fibonacci weights of all codeword bits that are 1. The result goes into an output register, together with a valid flag and a range flag.

A static two-bit mode input selects the weight set. Normal form gives every wire its own weight. The redundant and complement-redundant forms repeat the smallest weight on the two lowest wires. The two redundant forms decode with the same weights, because a complement-redundant codeword is the bitwise inverse of the redundant code for the mirrored value.

Top module: `fib_bus_decoder`

## Requirements
- R1: A synchronous active-high reset clears data, data_vld and range_err to 0 and clears the stored bus value to 0, so the first valid word after reset decodes the bus bits themselves as the codeword.
- R2: The codeword is bus XOR the stored bus value. The stored value takes the bus only on cycles with bus_vld high; bus values seen while bus_vld is low have no effect on later decoding.
- R3: Sequence g(0)=1, g(1)=2, g(k)=g(k-1)+g(k-2). In mode 0 (and in the spare code 3) codeword bit k carries weight g(k).
- R4: In mode 1 (redundant) codeword bit 0 carries weight 1 and bit k>=1 carries weight g(k-1), so bits 1 and 0 both weigh 1.
- R5: Mode 2 (complement-redundant) uses the R4 weights. The complement of the redundant code for T-d, where T is the sum of all R4 weights, decodes to d.
- R6: data_vld is high in exactly the cycle after each cycle in which bus_vld is high, and low otherwise.
- R7: data and range_err are loaded only on bus_vld cycles and hold their value otherwise.
- R8: range_err is 1 when the weighted sum exceeds 2^DATA_W-1; data then carries the low DATA_W bits of the sum.
- R9: Every data value 0..2^DATA_W-1 sent through a transition-signalled stream of encoded words returns unchanged in all modes. In mode 0 such a stream never toggles two adjacent wires in opposite directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Weight set: 0 normal, 1 redundant, 2 complement-redundant, 3 as 0 |
| bus_vld | input | 1 | Bus carries a new transition-coded word this cycle |
| bus | input | CODE_W | Wire values of the coded bus |
| data_vld | output | 1 | Registered data is new this cycle |
| data | output | DATA_W | Decoded data word |
| range_err | output | 1 | Weighted sum exceeded the data range |

## Verification
The bench builds two instances. The first uses the default four-wire, three-bit build, where every value in every mode can be swept and an all-ones codeword overflows the range. The second uses a ten-wire, seven-bit build whose upper weights of 55 and 89 exercise a long adder chain, fed by a seeded random stream after an exhaustive sweep. Both instances run from a bench-side encoder, and a second reset in the middle of the run shows that the history is cleared.

// File: rtl/fibdec_pkg.sv
package fibdec_pkg;

  typedef enum logic [1:0] {
    FW_NORMAL  = 2'd0,
    FW_REDUND  = 2'd1,
    FW_CREDUND = 2'd2,
    FW_SPARE   = 2'd3
  } fib_wmode_e;

  // g(0)=1, g(1)=2, g(k)=g(k-1)+g(k-2)
  function automatic int fib_term(input int k);
    int a;
    int b;
    int t;
    a = 1;
    b = 2;
    if (k <= 0) return 1;
    for (int i = 1; i < k; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return b;
  endfunction

  // largest possible sum: every normal-form weight set
  function automatic int normal_total(input int m);
    int s;
    s = 0;
    for (int k = 0; k < m; k++) s += fib_term(k);
    return s;
  endfunction

  function automatic int sum_width(input int m);
    return $clog2(normal_total(m) + 1);
  endfunction

  function automatic logic is_redundant(input fib_wmode_e md);
    return (md == FW_REDUND) || (md == FW_CREDUND);
  endfunction

endpackage

// File: rtl/fibdec_history.sv
module fibdec_history #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_vld,
  input  logic [CODE_W-1:0] bus,
  output logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] prev_bus
);

  always_ff @(posedge clk) begin
    if (rst) prev_bus <= '0;
    else if (bus_vld) prev_bus <= bus;
  end

  // undo transition signalling
  assign code = bus ^ prev_bus;

  a_r2_hist_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_vld |=> $stable(prev_bus));

  a_r2_hist_load: assert property (@(posedge clk) disable iff (rst)
    bus_vld |=> prev_bus == $past(bus));

endmodule

// File: rtl/fibdec_weights.sv
module fibdec_weights
  import fibdec_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int SUM_W  = 4
) (
  input  logic [1:0]                   mode,
  output logic [CODE_W-1:0][SUM_W-1:0] weights,
  output logic                         redund
);

  assign redund = is_redundant(fib_wmode_e'(mode));

  for (genvar k = 0; k < CODE_W; k++) begin : g_w
    localparam int NW = fib_term(k);
    localparam int RW = (k == 0) ? 1 : fib_term(k - 1);
    assign weights[k] = redund ? SUM_W'(RW) : SUM_W'(NW);
  end

endmodule

// File: rtl/fibdec_sum.sv
module fibdec_sum #(
  parameter int CODE_W = 4,
  parameter int SUM_W  = 4,
  parameter int DATA_W = 3
) (
  input  logic [CODE_W-1:0]            code,
  input  logic [CODE_W-1:0][SUM_W-1:0] weights,
  output logic [SUM_W-1:0]             sum,
  output logic                         over_range
);

  localparam int DMAX = (1 << DATA_W) - 1;

  always_comb begin
    sum = '0;
    for (int k = 0; k < CODE_W; k++) begin
      if (code[k]) sum = sum + weights[k];
    end
  end

  assign over_range = int'(sum) > DMAX;

endmodule

// File: rtl/fib_bus_decoder.sv
module fib_bus_decoder
  import fibdec_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int DATA_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              bus_vld,
  input  logic [CODE_W-1:0] bus,
  output logic              data_vld,
  output logic [DATA_W-1:0] data,
  output logic              range_err
);

  localparam int SUM_W = sum_width(CODE_W);

  logic [CODE_W-1:0]            code_w;
  logic [CODE_W-1:0]            prev_w;
  logic [CODE_W-1:0][SUM_W-1:0] weight_w;
  logic                         redund_w;
  logic [SUM_W-1:0]             sum_w;
  logic                         over_w;

  fibdec_history #(.CODE_W(CODE_W)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .bus_vld  (bus_vld),
    .bus      (bus),
    .code     (code_w),
    .prev_bus (prev_w)
  );

  fibdec_weights #(.CODE_W(CODE_W), .SUM_W(SUM_W)) u_wts (
    .mode    (mode),
    .weights (weight_w),
    .redund  (redund_w)
  );

  fibdec_sum #(.CODE_W(CODE_W), .SUM_W(SUM_W), .DATA_W(DATA_W)) u_sum (
    .code       (code_w),
    .weights    (weight_w),
    .sum        (sum_w),
    .over_range (over_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_vld  <= 1'b0;
      data      <= '0;
      range_err <= 1'b0;
    end else begin
      data_vld <= bus_vld;
      if (bus_vld) begin
        data      <= sum_w[DATA_W-1:0];
        range_err <= over_w;
      end
    end
  end

  a_r6_vld_rise: assert property (@(posedge clk) disable iff (rst)
    bus_vld |=> data_vld);

  a_r6_vld_fall: assert property (@(posedge clk) disable iff (rst)
    !bus_vld |=> !data_vld);

  a_r7_data_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_vld |=> ($stable(data) && $stable(range_err)));

  a_r8_data_low: assert property (@(posedge clk) disable iff (rst)
    bus_vld |=> data == $past(sum_w[DATA_W-1:0]));

  a_r8_err_flag: assert property (@(posedge clk) disable iff (rst)
    bus_vld |=> range_err == $past(over_w));

  a_r4_low_pair: assert property (@(posedge clk) disable iff (rst)
    redund_w |-> weight_w[0] == weight_w[CODE_W > 1 ? 1 : 0]);

endmodule

// File: tb/tb_fib_bus_decoder.sv
module tb_fib_bus_decoder;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic [1:0] s_mode, w_mode;
  logic s_vld, w_vld;
  logic [3:0] s_bus;
  logic [9:0] w_bus;
  logic s_ovld, w_ovld, s_err, w_err;
  logic [2:0] s_data;
  logic [6:0] w_data;
  logic [15:0] s_hist, w_hist;
  int n_chk = 0;
  int n_fail = 0;

  fib_bus_decoder #(.CODE_W(4), .DATA_W(3)) dut (
    .clk(clk), .rst(rst), .mode(s_mode), .bus_vld(s_vld), .bus(s_bus),
    .data_vld(s_ovld), .data(s_data), .range_err(s_err));

  fib_bus_decoder #(.CODE_W(10), .DATA_W(7)) dut_wide (
    .clk(clk), .rst(rst), .mode(w_mode), .bus_vld(w_vld), .bus(w_bus),
    .data_vld(w_ovld), .data(w_data), .range_err(w_err));

  // bench-side weight rule, built from a table of terms
  function automatic int bweight(input int md, input int k);
    int g[0:24];
    g[0] = 1; g[1] = 2;
    for (int i = 2; i <= 24; i++) g[i] = g[i-1] + g[i-2];
    if ((md == 1 || md == 2) && k > 0) return g[k-1];
    return g[k];
  endfunction

  function automatic int rtotal(input int m);
    int s = 0;
    for (int k = 0; k < m; k++) s += bweight(1, k);
    return s;
  endfunction

  function automatic logic [15:0] benc(input int md, input int d, input int m);
    logic [15:0] c = '0;
    int r;
    int em;
    em = (md == 3) ? 0 : md;
    r  = (em == 2) ? rtotal(m) - d : d;
    for (int k = m - 1; k >= 0; k--) begin
      if (r >= bweight(em, k)) begin
        c[k] = 1'b1;
        r -= bweight(em, k);
      end
    end
    if (em == 2) c = ~c & 16'((1 << m) - 1);
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input bit wide, input logic [1:0] md, input logic [15:0] b);
    @(negedge clk);
    if (wide) begin
      w_mode = md; w_bus = b[9:0]; w_vld = 1'b1; w_hist = b;
    end else begin
      s_mode = md; s_bus = b[3:0]; s_vld = 1'b1; s_hist = b;
    end
    @(negedge clk);
    w_vld = 1'b0;
    s_vld = 1'b0;
  endtask

  task automatic roundtrip(input bit wide, input int md, input int d, input string tag);
    int m;
    logic [15:0] code, oldb, nb;
    m    = wide ? 10 : 4;
    code = benc(md, d, m);
    oldb = wide ? w_hist : s_hist;
    nb   = oldb ^ code;
    if (md == 0) begin
      int bad = 0;
      for (int k = 0; k < m - 1; k++)
        if (code[k] && code[k+1] && (oldb[k] != oldb[k+1])) bad++;
      chk("R9 opposite adjacent toggles", bad, 0);
    end
    send(wide, 2'(md), nb);
    chk({tag, " data"}, wide ? int'(w_data) : int'(s_data), d);
    chk({tag, " data_vld"}, wide ? int'(w_ovld) : int'(s_ovld), 1);
    chk({tag, " range_err"}, wide ? int'(w_err) : int'(s_err), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int old;
    logic [15:0] nb;
    void'($urandom(32'd20250611));
    rst = 1'b1; s_vld = 0; w_vld = 0; s_mode = 0; w_mode = 0;
    s_bus = 0; w_bus = 0; s_hist = 0; w_hist = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset data", int'(s_data), 0);
    chk("R1 reset data_vld", int'(s_ovld), 0);
    chk("R1 reset range_err", int'(w_err), 0);
    chk("R1 reset wide data", int'(w_data), 0);
    rst = 1'b0;

    // first word: history is zero
    roundtrip(0, 0, 6, "R1 first word");

    // exhaustive sweeps, small build
    for (int md = 0; md < 4; md++)
      for (int d = 0; d < 8; d++)
        roundtrip(0, md, d, md == 1 ? "R4 small" : md == 2 ? "R5 small" :
                  "R3 small");

    // idle cycle: no valid output, held data
    old = int'(s_data);
    @(negedge clk);
    chk("R6 data_vld low after idle", int'(s_ovld), 0);
    chk("R7 data held", int'(s_data), old);

    // bus noise with valid low must not move history
    @(negedge clk); s_bus = 4'($urandom);
    @(negedge clk); s_bus = 4'($urandom);
    @(negedge clk);
    chk("R7 data held under noise", int'(s_data), old);
    chk("R6 data_vld low under noise", int'(s_ovld), 0);
    roundtrip(0, 1, 5, "R2 history ignores noise");

    // range boundary
    nb = s_hist ^ 16'h000F; send(0, 2'd0, nb);
    chk("R8 small all-ones err", int'(s_err), 1);
    chk("R8 small all-ones data", int'(s_data), 3);
    nb = s_hist ^ 16'h000F; send(0, 2'd1, nb);
    chk("R8 small redundant sum 7 err", int'(s_err), 0);
    chk("R4 small redundant sum 7 data", int'(s_data), 7);
    nb = w_hist ^ 16'h03FF; send(1, 2'd0, nb);
    chk("R8 wide all-ones err", int'(w_err), 1);
    chk("R8 wide all-ones data", int'(w_data), 103);
    nb = w_hist ^ 16'h03FF; send(1, 2'd1, nb);
    chk("R8 wide redundant err", int'(w_err), 1);
    chk("R8 wide redundant data", int'(w_data), 15);

    // exhaustive and random, wide build
    for (int md = 0; md < 3; md++)
      for (int d = 0; d < 128; d++)
        roundtrip(1, md, d, md == 1 ? "R4 wide" : md == 2 ? "R5 wide" :
                  "R3 wide");
    for (int i = 0; i < 200; i++)
      roundtrip(1, int'($urandom % 4), int'($urandom % 128), "R9 wide random");

    // second reset clears history
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    s_hist = 0; w_hist = 0;
    chk("R1 second reset data_vld", int'(w_ovld), 0);
    roundtrip(1, 0, 100, "R1 history cleared");
    roundtrip(0, 2, 4, "R1 history cleared small");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule